// File: doc/BRIEF.md
# Byte-Wide EPROM Mode Decoder and Array Model

This block is a synthesizable behavioural stand-in for a byte-wide, ultraviolet-erasable programmable ROM. Other logic can use it as a test target. Each clock it samples the following inputs:

- an active-low chip select;
- an active-low output gate;
- an active-low program strobe;
- a flag that says the programming supply is raised;
- a flag that says the high-voltage identifier level is present on address line 9.

From these it picks one operating mode. It then either drives a byte with a matching output-enable flag, or leaves the bus undriven. Supply levels are reduced to single-bit flags. Timing delays are not modelled.

The array starts fully erased, with every bit at one. A program operation can only clear bits, so the new stored byte is the old byte ANDed with the supplied data. A program operation is captured when the strobe returns high, using the address and data present at that moment. The only way back to all ones is the erase input. Erase sweeps the array one word per clock and raises a busy flag while it runs.

When the identifier flag is raised under read conditions, the block returns two fixed identifier bytes instead of array data. Address bit 0 chooses between them. Any input combination outside the defined modes leaves the bus undriven and sets a sticky illegal-mode flag.

Top module: `eprom_mode_model`

## Requirements
- R1: In read mode, the data output and `dout_en=1` follow the current address in the same cycle, and the data is the stored byte. Read mode is: supply flag low, `cs_n=0`, `gate_n=0`, `strobe_n=1`, identifier flag low.
- R2: With the supply flag low, two cases give `dout_en=0`. The first is `cs_n=1` (standby), whatever the other controls are. The second is `cs_n=0` with `gate_n=1` (output disabled).
- R3: With the supply flag high and `cs_n=0`, a strobe low for one or more sampled cycles followed by a sampled high writes `old AND din` to the addressed word. Address and data are taken in the cycle where the strobe is seen high. The result is readable from the next cycle.
- R4: Verify mode outputs the stored byte with `dout_en=1` in the same cycle. Verify mode is: supply flag high, `cs_n=0`, `gate_n=0`, `strobe_n=1`.
- R5: With the supply flag high and `cs_n=1`, `dout_en=0`, and a strobe pulse leaves the array unchanged.
- R6: Under read conditions with the identifier flag high, the output is 8'h20 when address bit 0 is 0 and 8'h61 when it is 1, with `dout_en=1`.
- R7: A sampled `erase_req` while idle raises `erase_busy` from the next cycle for exactly DEPTH cycles. After that every word reads 8'hFF. While busy, `dout_en=0`, and strobe pulses write nothing.
- R8: `cs_n=0`, `gate_n=0` and `strobe_n=0` together, at any supply level, give `dout_en=0`. From the next cycle they also set `illegal_mode`, which stays set until reset.
- R9: After reset the array reads all ones and `erase_busy=0`, `illegal_mode=0`. With `cs_n=1`, `dout_en=0`.
- R10: With the supply flag high, `cs_n=0`, `gate_n=1` and `strobe_n=1`, `dout_en=0` and `illegal_mode` stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| gate_n | input | 1 | Output gate, active low |
| strobe_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identifier level present on address line 9 |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Data to program |
| erase_req | input | 1 | Start a full erase |
| dout | output | 8 | Output byte |
| dout_en | output | 1 | Output byte is driven |
| erase_busy | output | 1 | Erase sweep in progress |
| illegal_mode | output | 1 | Sticky undefined-mode flag |

## Verification
Mode decoding, read, verify and identifier data are combinational. The bench checks them one time unit after it drives the inputs on the falling edge, before the next rising edge.

A programmed byte, the illegal flag and the start of busy all appear after the rising edge that samples their cause. The bench checks them at the falling edge that follows.

The erase length is measured by counting falling-edge samples with busy high. The expected count is DEPTH, with no fixed wait.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

   typedef enum logic [3:0] {
      MD_STANDBY  = 4'd0,
      MD_OUTOFF   = 4'd1,
      MD_READ     = 4'd2,
      MD_IDENT    = 4'd3,
      MD_PROGRAM  = 4'd4,
      MD_PGMIDLE  = 4'd5,
      MD_VERIFY   = 4'd6,
      MD_INHIBIT  = 4'd7,
      MD_ILLEGAL  = 4'd8
   } eprom_mode_e;

   // Combinational mode selection from the sampled control flags.
   function automatic eprom_mode_e pick_mode(input logic cs_n,
                                             input logic gate_n,
                                             input logic strobe_n,
                                             input logic vpp_hi,
                                             input logic id_hv);
      eprom_mode_e m;
      if (!cs_n && !gate_n && !strobe_n) begin
         m = MD_ILLEGAL;
      end else if (!vpp_hi) begin
         if (cs_n)        m = MD_STANDBY;
         else if (gate_n) m = MD_OUTOFF;
         else             m = id_hv ? MD_IDENT : MD_READ;
      end else begin
         if (cs_n)           m = MD_INHIBIT;
         else if (!strobe_n) m = MD_PROGRAM;
         else if (!gate_n)   m = MD_VERIFY;
         else                m = MD_PGMIDLE;
      end
      return m;
   endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
   import eprom_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs_n,
   input  logic        gate_n,
   input  logic        strobe_n,
   input  logic        vpp_hi,
   input  logic        id_hv,
   output eprom_mode_e mode,
   output logic       wr_fire,
   output logic       illegal_seen
);

   logic armed_q;

   always_comb mode = pick_mode(cs_n, gate_n, strobe_n, vpp_hi, id_hv);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q      <= 1'b0;
         illegal_seen <= 1'b0;
      end else begin
         armed_q <= (mode == MD_PROGRAM);
         if (mode == MD_ILLEGAL) illegal_seen <= 1'b1;
      end
   end

   // Rising strobe while the supply is raised and the chip selected.
   always_comb wr_fire = armed_q && strobe_n && vpp_hi && !cs_n;

   // R3
   wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |-> $past(!strobe_n));

   // R8
   sticky_ill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_seen |=> illegal_seen);

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_fire,
   input  logic              erase_req,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   logic [DATA_W-1:0] cells [DEPTH];
   logic [ADDR_W-1:0] sweep_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         sweep_idx <= '0;
      end else if (busy) begin
         sweep_idx <= sweep_idx + 1'b1;
         if (sweep_idx == LAST) busy <= 1'b0;
      end else if (erase_req) begin
         busy      <= 1'b1;
         sweep_idx <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (busy) begin
         cells[sweep_idx] <= '1;
      end else if (wr_fire) begin
         cells[addr] <= cells[addr] & wr_data;
      end
   end

   always_comb rd_data = cells[addr];

   // R7
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(erase_req));

   // R7
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sweep_idx == LAST) |=> !busy);

endmodule

// File: rtl/eprom_out_mux.sv
module eprom_out_mux
   import eprom_pkg::*;
#(
   parameter int          DATA_W   = 8,
   parameter bit          OUT_REG  = 1'b0,
   parameter logic [7:0]  MFR_ID   = 8'h20,
   parameter logic [7:0]  DEV_ID   = 8'h61
) (
   input  logic              clk,
   input  logic              rst_n,
   input  eprom_mode_e       mode,
   input  logic              busy,
   input  logic              sel_bit0,
   input  logic [DATA_W-1:0] arr_data,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   logic [DATA_W-1:0] nxt_data;
   logic              nxt_en;

   always_comb begin
      nxt_en   = 1'b0;
      nxt_data = '0;
      if (!busy) begin
         unique case (mode)
            MD_READ, MD_VERIFY: begin
               nxt_en   = 1'b1;
               nxt_data = arr_data;
            end
            MD_IDENT: begin
               nxt_en   = 1'b1;
               nxt_data = DATA_W'(sel_bit0 ? DEV_ID : MFR_ID);
            end
            default: ;
         endcase
      end
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dout    <= '0;
               dout_en <= 1'b0;
            end else begin
               dout    <= nxt_data;
               dout_en <= nxt_en;
            end
         end
      end else begin : g_comb
         always_comb begin
            dout    = nxt_data;
            dout_en = nxt_en;
         end
      end
   endgenerate

endmodule

// File: rtl/eprom_mode_model.sv
module eprom_mode_model
   import eprom_pkg::*;
#(
   parameter int         ADDR_W  = 10,
   parameter int         DATA_W  = 8,
   parameter bit         OUT_REG = 1'b0,
   parameter logic [7:0] MFR_ID  = 8'h20,
   parameter logic [7:0] DEV_ID  = 8'h61
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              gate_n,
   input  logic              strobe_n,
   input  logic              vpp_hi,
   input  logic              id_hv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              erase_req,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              erase_busy,
   output logic              illegal_mode
);

   generate
      if (ADDR_W < 1 || ADDR_W > 14) begin : g_bad_addr
         $error("ADDR_W out of supported range");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold the identifier bytes");
      end
   endgenerate

   eprom_mode_e       mode;
   logic              wr_fire;
   logic [DATA_W-1:0] arr_data;

   eprom_mode_decode u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_n         (cs_n),
      .gate_n       (gate_n),
      .strobe_n     (strobe_n),
      .vpp_hi       (vpp_hi),
      .id_hv        (id_hv),
      .mode         (mode),
      .wr_fire      (wr_fire),
      .illegal_seen (illegal_mode)
   );

   eprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .wr_data   (din),
      .wr_fire   (wr_fire),
      .erase_req (erase_req),
      .rd_data   (arr_data),
      .busy      (erase_busy)
   );

   eprom_out_mux #(.DATA_W(DATA_W), .OUT_REG(OUT_REG),
                   .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .busy     (erase_busy),
      .sel_bit0 (addr[0]),
      .arr_data (arr_data),
      .dout     (dout),
      .dout_en  (dout_en)
   );

   generate
      if (!OUT_REG) begin : g_port_chk
         // R2
         stby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cs_n |-> !dout_en);
         // R8
         ill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cs_n && !gate_n && !strobe_n) |-> !dout_en);
         // R7
         erase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            erase_busy |-> !dout_en);
      end
   endgenerate

endmodule

// File: tb/sim_eprom_mode_model.sv
module sim_eprom_mode_model;

   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, gate_n = 1'b1, strobe_n = 1'b1;
   logic          vpp_hi = 1'b0, id_hv = 1'b0, erase_req = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    din = '0;
   logic [7:0]    dout;
   logic          dout_en, erase_busy, illegal_mode;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   logic [7:0]  model [DEPTH];

   always #2 clk = ~clk;

   eprom_mode_model #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .gate_n(gate_n),
      .strobe_n(strobe_n), .vpp_hi(vpp_hi), .id_hv(id_hv), .addr(addr),
      .din(din), .erase_req(erase_req), .dout(dout), .dout_en(dout_en),
      .erase_busy(erase_busy), .illegal_mode(illegal_mode)
   );

   function automatic logic [7:0] prog_result(logic [7:0] old_v, logic [7:0] nw);
      return old_v & nw;
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(logic c, logic g, logic s, logic v, logic h,
                        logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk);
      cs_n = c; gate_n = g; strobe_n = s; vpp_hi = v; id_hv = h;
      addr = a; din = d;
      #1;
   endtask

   task automatic rd_chk(string tag, logic [AW-1:0] a);
      drive(0, 0, 1, 0, 0, a, 8'h00);
      chk(tag, {7'd0, dout_en, dout}, {7'd0, 1'b1, model[a]});
   endtask

   task automatic prog(logic c, logic [AW-1:0] a, logic [7:0] d);
      drive(c, 1, 1, 1, 0, a, d);
      drive(c, 1, 0, 1, 0, a, d);
      drive(c, 1, 1, 1, 0, a, d);
      if (!c && !erase_busy) model[a] = prog_result(model[a], d);
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int unsigned seed;
      int          cnt;
      seed = $urandom(32'd4242);
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9 reset state
      chk("R9 busy", {15'd0, erase_busy}, 16'd0);
      chk("R9 illegal", {15'd0, illegal_mode}, 16'd0);
      chk("R9 dout_en", {15'd0, dout_en}, 16'd0);
      rd_chk("R9 erased read", 10'd5);

      // R3 and R1: program then read, AND behaviour
      prog(0, 10'd3, 8'hA5);
      rd_chk("R3 first write", 10'd3);
      prog(0, 10'd3, 8'h3C);
      rd_chk("R3 and write", 10'd3);
      chk("R3 value", {8'd0, model[3]}, 16'h0024);
      prog(0, 10'd3, 8'hFF);
      rd_chk("R3 ones not restored", 10'd3);

      // R4 verify
      drive(0, 0, 1, 1, 0, 10'd3, 8'h00);
      chk("R4 verify", {7'd0, dout_en, dout}, {7'd0, 1'b1, 8'h24});

      // R5 inhibit
      drive(1, 0, 1, 1, 0, 10'd7, 8'h00);
      chk("R5 inhibit hiz", {15'd0, dout_en}, 16'd0);
      prog(1, 10'd7, 8'h00);
      rd_chk("R5 no write", 10'd7);

      // R10 programming idle
      drive(0, 1, 1, 1, 0, 10'd7, 8'h00);
      chk("R10 hiz", {15'd0, dout_en}, 16'd0);
      drive(0, 1, 1, 1, 0, 10'd7, 8'h00);
      chk("R10 not illegal", {15'd0, illegal_mode}, 16'd0);

      // R6 identifier
      drive(0, 0, 1, 0, 1, 10'h000, 8'h00);
      chk("R6 mfr", {7'd0, dout_en, dout}, {7'd0, 1'b1, 8'h20});
      drive(0, 0, 1, 0, 1, 10'h001, 8'h00);
      chk("R6 dev", {7'd0, dout_en, dout}, {7'd0, 1'b1, 8'h61});

      // R2 standby and output disable
      drive(1, 0, 1, 0, 0, 10'd3, 8'h00);
      chk("R2 standby", {15'd0, dout_en}, 16'd0);
      drive(0, 1, 1, 0, 0, 10'd3, 8'h00);
      chk("R2 outoff", {15'd0, dout_en}, 16'd0);

      // Random mix of program, read, verify, standby
      for (int k = 0; k < 400; k++) begin
         logic [AW-1:0] ra;
         logic [7:0]    rd;
         int unsigned   op;
         ra = AW'($urandom % DEPTH);
         rd = 8'($urandom);
         op = $urandom % 5;
         case (op)
            0: prog(0, ra, rd);
            1: prog(1, ra, rd);
            2: rd_chk("R1 random read", ra);
            3: begin
               drive(0, 0, 1, 1, 0, ra, 8'h00);
               chk("R4 random verify", {7'd0, dout_en, dout}, {7'd0, 1'b1, model[ra]});
            end
            default: begin
               drive(1, $urandom % 2, 1, 0, 0, ra, 8'h00);
               chk("R2 random standby", {15'd0, dout_en}, 16'd0);
            end
         endcase
      end

      // R7 erase
      drive(1, 1, 1, 0, 0, 10'd3, 8'h00);
      @(negedge clk); erase_req = 1'b1;
      @(negedge clk); erase_req = 1'b0;
      #1;
      chk("R7 busy rises", {15'd0, erase_busy}, 16'd1);
      cnt = 1;
      drive(0, 0, 1, 0, 0, 10'd3, 8'h00);
      chk("R7 quiet while busy", {15'd0, dout_en}, 16'd0);
      cnt++;
      prog(0, 10'd900, 8'h00);
      cnt += 3;
      while (erase_busy) begin
         @(negedge clk); #1;
         if (erase_busy) cnt++;
      end
      chk("R7 busy length", 16'(cnt), 16'(DEPTH));
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
      rd_chk("R7 erased 3", 10'd3);
      rd_chk("R7 erased 900", 10'd900);
      rd_chk("R7 erased top", 10'(DEPTH - 1));

      // R8 illegal combination
      drive(0, 0, 0, 0, 0, 10'd3, 8'h00);
      chk("R8 hiz", {15'd0, dout_en}, 16'd0);
      drive(0, 0, 1, 0, 0, 10'd3, 8'h00);
      chk("R8 flag set", {15'd0, illegal_mode}, 16'd1);
      repeat (3) drive(1, 1, 1, 0, 0, 10'd3, 8'h00);
      chk("R8 flag sticky", {15'd0, illegal_mode}, 16'd1);
      rd_chk("R8 read still works", 10'd3);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule